// File: doc/BRIEF.md
# Serial Flash Security Register Reader

This block is the target end of a single-bit SPI link that answers one command: a read of three small one-time security pages, each 512 bytes deep, kept in an on-chip store. The host lowers chip select, clocks in an 8-bit opcode, a 24-bit address and one dummy byte on the serial input, and then receives a stream of bytes on the serial output for as long as it keeps clocking. Raising chip select ends the transfer at any point.

The serial clock, chip select and serial input are brought into the block's system clock domain by a two-stage synchronizer, so the serial clock has to be several times slower than the system clock. The upper address bits select one of the three pages. The low nine bits give the starting byte inside that page. Page contents are loaded through a plain parallel write port on the system clock, which lets a test environment or start-up logic fill them. There is no programming, erasing or locking over the serial link. The data path is single-bit only.

Top module: `secreg_reader`

## Requirements
- R1: A transfer is served only when the first 8 bits sampled after chip select falls, taken MSB first, equal 0x48. Any other opcode leaves the output disabled (spi_so_oe = 0) until chip select rises.
- R2: The 24 bits sampled on serial clocks 8 to 31 form the address, most significant bit first.
- R3: Serial clocks 32 to 39 carry a dummy byte whose value is ignored. The first data bit is driven on the falling serial clock edge that follows the 40th rising edge.
- R4: spi_so_oe stays 0 from chip select falling until that first data bit is driven.
- R5: Data bytes leave MSB first. Each later byte comes from the next offset in the same page, for as long as clocks continue.
- R6: The address selects a page only when bits 23..16 are 0x00 and bits 11..9 are 000. Bits 15..12 equal to 0001, 0010 or 0011 select the preload page index 0, 1 or 2 respectively.
- R7: Address bits 8..0 give the starting byte offset inside the selected page.
- R8: An address that selects no page returns 0xFF for every data byte.
- R9: During a long read the offset wraps from 511 back to 0 inside the same page.
- R10: When chip select is high, spi_so_oe is 0 with no clock delay. The next transfer then starts counting from its first opcode bit, wherever the previous one was cut off.
- R11: Serial input is sampled on rising serial clock edges. Serial output changes only on falling edges (SPI mode 0).
- R12: A write-port strobe (wr_en high on a rising clk) stores wr_data at wr_page/wr_offset. The stored byte is what a later serial read of that location returns.
- R13: While rst_n is low on a rising clk, the transfer state clears and spi_so_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for spi_so; 0 means high impedance |
| wr_en | input | 1 | Preload write strobe |
| wr_page | input | 2 | Preload page index 0..2 |
| wr_offset | input | 9 | Preload byte offset in the page |
| wr_data | input | 8 | Preload byte |

## Verification
The assertions check on every cycle that the header counter never runs past 40 bits and that the output is only enabled once the full header has arrived with a valid opcode. They also check that chip select high clears the transfer state, that an unmatched page drives only ones, and that the byte offset changes only at byte boundaries. Whether the right bytes come back depends on the page decode, the starting offset, the wrap at 511, the rejection of other opcodes and the restart after an aborted transfer. Only the bench's scenarios can show these, by comparing whole serial reads against a reference computed from the requirements.

// File: rtl/secreg_pkg.sv
// Shared constants and types for the security register reader.
// Assumes three pages of 512 bytes and a single-bit SPI header of
// opcode, 24-bit address and one dummy byte.
package secreg_pkg;
    parameter int PAGES      = 3;
    parameter int PAGE_BYTES = 512;
    parameter int OFF_W      = $clog2(PAGE_BYTES);
    parameter int PAGE_W     = 2;
    parameter int CMD_BITS   = 8;
    parameter int ADDR_BITS  = 24;
    parameter int DUMMY_BITS = 8;
    parameter int HDR_BITS   = CMD_BITS + ADDR_BITS + DUMMY_BITS;
    parameter logic [7:0] READ_OP = 8'h48;

    // Result of decoding the address field of a read command
    typedef struct packed {
        logic              hit;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  offset;
    } secreg_sel_t;
endpackage

// File: rtl/spi_edge_sync.sv
// Brings the SPI pins into the system clock domain and marks serial clock edges.
// Assumes the serial clock runs well below clk/4 so every level is seen.
// STAGES sets the synchronizer depth (at least 2).
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic si_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_idle_o,
    output logic si_o
);
    logic [STAGES-1:0] sclk_sh;
    logic [STAGES-1:0] cs_sh;
    logic [STAGES-1:0] si_sh;
    logic              sclk_d;

    // Shift each pin through its synchronizer chain and keep the last clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sh <= '0;
            cs_sh   <= '1;
            si_sh   <= '0;
            sclk_d  <= 1'b0;
        end else begin
            sclk_sh <= {sclk_sh[STAGES-2:0], sclk_i};
            cs_sh   <= {cs_sh[STAGES-2:0], cs_n_i};
            si_sh   <= {si_sh[STAGES-2:0], si_i};
            sclk_d  <= sclk_sh[STAGES-1];
        end
    end

    // Edge strobes and synchronized levels
    always_comb begin
        sclk_rise_o = sclk_sh[STAGES-1] & ~sclk_d;
        sclk_fall_o = ~sclk_sh[STAGES-1] & sclk_d;
        cs_idle_o   = cs_sh[STAGES-1];
        si_o        = si_sh[STAGES-1];
    end
endmodule

// File: rtl/secreg_addr_decode.sv
// Maps a 24-bit read address to a page index and byte offset.
// A page is hit only with a zero top byte, zero bits 11..9 and bits 15..12
// equal to the page number plus one.
module secreg_addr_decode
    import secreg_pkg::*;
#(
    parameter int NPAGES = PAGES
) (
    input  logic [ADDR_BITS-1:0] addr_i,
    output secreg_sel_t          sel_o
);
    localparam int OFF_TOP = OFF_W;

    logic [NPAGES-1:0] match;
    logic              base_ok;

    // Fixed fields that must be zero for any page
    always_comb base_ok = (addr_i[23:16] == 8'h00) && (addr_i[11:OFF_TOP] == '0);

    // One comparator per page
    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        always_comb match[p] = base_ok && (addr_i[15:12] == 4'(p + 1));
    end

    // Encode the matching page into the selection record
    always_comb begin
        sel_o        = '0;
        sel_o.offset = addr_i[OFF_W-1:0];
        for (int p = 0; p < NPAGES; p++) begin
            if (match[p]) begin
                sel_o.hit  = 1'b1;
                sel_o.page = PAGE_W'(p);
            end
        end
    end
endmodule

// File: rtl/secreg_store.sv
// Byte store for all pages: synchronous write port, asynchronous read port.
// Writes to a page index at or above NPAGES are dropped.
module secreg_store
    import secreg_pkg::*;
#(
    parameter int NPAGES = PAGES,
    parameter int NBYTES = PAGE_BYTES
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [PAGE_W-1:0] wr_page_i,
    input  logic [OFF_W-1:0]  wr_offset_i,
    input  logic [7:0]        wr_data_i,
    input  logic [PAGE_W-1:0] rd_page_i,
    input  logic [OFF_W-1:0]  rd_offset_i,
    output logic [7:0]        rd_data_o
);
    localparam int DEPTH = NPAGES * NBYTES;
    localparam int IDX_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    // Flat indices from page and offset
    always_comb begin
        wr_idx = IDX_W'(int'(wr_page_i) * NBYTES + int'(wr_offset_i));
        rd_idx = IDX_W'(int'(rd_page_i) * NBYTES + int'(rd_offset_i));
    end

    // Preload write
    always_ff @(posedge clk) begin
        if (wr_en_i && int'(wr_page_i) < NPAGES)
            mem[wr_idx] <= wr_data_i;
    end

    // Read of the byte being shifted out
    always_comb rd_data_o = (int'(rd_page_i) < NPAGES) ? mem[rd_idx] : 8'hFF;
endmodule

// File: rtl/secreg_reader.sv
// SPI mode 0 target that serves the security register read command.
// Counts header bits on rising serial clocks, latches the decoded address
// after bit 31 and shifts bytes out on falling edges after bit 39.
// Assumes clk is at least 8x the serial clock.
module secreg_reader
    import secreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [OFF_W-1:0]  wr_offset,
    input  logic [7:0]        wr_data
);
    localparam int CNT_W     = $clog2(HDR_BITS + 1);
    localparam int WORD_BITS = CMD_BITS + ADDR_BITS;
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(WORD_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_DONE  = CNT_W'(HDR_BITS);

    logic                 sclk_rise, sclk_fall, cs_idle, si_s;
    logic [CNT_W-1:0]     cnt_q;
    logic [WORD_BITS-1:0] shift_q;
    logic [WORD_BITS-1:0] word;
    logic                 op_ok_q;
    secreg_sel_t          sel_d, sel_q;
    logic                 data_q;
    logic [2:0]           bit_q;
    logic [OFF_W-1:0]     off_q;
    logic                 so_q;
    logic [7:0]           store_byte;
    logic [7:0]           out_byte;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .cs_n_i      (spi_cs_n),
        .si_i        (spi_si),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .cs_idle_o   (cs_idle),
        .si_o        (si_s)
    );

    // Opcode and address as they stand including the bit arriving now
    always_comb word = {shift_q[WORD_BITS-2:0], si_s};

    secreg_addr_decode #(.NPAGES(PAGES)) u_dec (
        .addr_i (word[ADDR_BITS-1:0]),
        .sel_o  (sel_d)
    );

    secreg_store #(.NPAGES(PAGES), .NBYTES(PAGE_BYTES)) u_store (
        .clk         (clk),
        .wr_en_i     (wr_en),
        .wr_page_i   (wr_page),
        .wr_offset_i (wr_offset),
        .wr_data_i   (wr_data),
        .rd_page_i   (sel_q.page),
        .rd_offset_i (off_q),
        .rd_data_o   (store_byte)
    );

    // Unmatched addresses read as all ones
    always_comb out_byte = sel_q.hit ? store_byte : 8'hFF;

    // Header capture on rising edges, data shift on falling edges
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            cnt_q   <= '0;
            shift_q <= '0;
            op_ok_q <= 1'b0;
            sel_q   <= '0;
            data_q  <= 1'b0;
            bit_q   <= '0;
            off_q   <= '0;
            so_q    <= 1'b1;
        end else begin
            if (sclk_rise && cnt_q < HDR_DONE) begin
                cnt_q   <= cnt_q + 1'b1;
                shift_q <= word;
                if (cnt_q == LAST_ADDR) begin
                    op_ok_q <= (word[WORD_BITS-1 -: CMD_BITS] == READ_OP);
                    sel_q   <= sel_d;
                    off_q   <= sel_d.offset;
                end
            end
            if (sclk_fall && cnt_q == HDR_DONE && op_ok_q) begin
                data_q <= 1'b1;
                so_q   <= out_byte[3'd7 - bit_q];
                bit_q  <= bit_q + 3'd1;
                if (bit_q == 3'd7)
                    off_q <= off_q + 1'b1;
            end
        end
    end

    // Output enable drops with the raw chip select, without waiting for clk
    always_comb begin
        spi_so    = so_q;
        spi_so_oe = data_q & ~spi_cs_n;
    end

    // Header counter never passes the header length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= HDR_DONE);

    // Output is enabled only after the whole header
    p_hiz_header_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_q |-> cnt_q == HDR_DONE);

    // Data only follows a matching opcode
    p_opcode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        data_q |-> op_ok_q);

    // Chip select high clears the transfer
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (cnt_q == '0 && !data_q && bit_q == '0));

    // Unmatched page drives ones only
    p_miss_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q && !sel_q.hit) |-> so_q);

    // In the data phase the offset moves only at a byte boundary
    p_offset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q && !cs_idle && !(sclk_fall && bit_q == 3'd7)) |=> $stable(off_q));

    // Output bit changes only on a falling serial edge
    p_so_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q && !cs_idle && !sclk_fall) |=> $stable(so_q));
endmodule

// File: tb/secreg_reader_tb.sv
module secreg_reader_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_si = 1'b0;
    logic       spi_so;
    logic       spi_so_oe;
    logic       wr_en = 1'b0;
    logic [1:0] wr_page = '0;
    logic [8:0] wr_offset = '0;
    logic [7:0] wr_data = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    secreg_reader u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_si    (spi_si),
        .spi_so    (spi_so),
        .spi_so_oe (spi_so_oe),
        .wr_en     (wr_en),
        .wr_page   (wr_page),
        .wr_offset (wr_offset),
        .wr_data   (wr_data)
    );

    // Vector fields: opcode[47:40], address[39:16], byte count[15:0]
    localparam int NVEC = 8;
    localparam logic [47:0] VECS [NVEC] = '{
        {8'h48, 24'h001000, 16'd4},   // page 0, offset 0
        {8'h48, 24'h002064, 16'd3},   // page 1, offset 100
        {8'h48, 24'h0031FE, 16'd4},   // page 2, wraps 511 -> 0
        {8'h48, 24'h0011FF, 16'd2},   // page 0, wrap at once
        {8'h48, 24'h004000, 16'd2},   // bits 15..12 = 0100: miss
        {8'h48, 24'h011000, 16'd2},   // top byte nonzero: miss
        {8'h48, 24'h001200, 16'd2},   // bits 11..9 nonzero: miss
        {8'h0B, 24'h001000, 16'd2}    // other opcode: no output
    };

    function automatic logic [7:0] pat(input int p, input int o);
        return 8'(o) ^ 8'((o >> 8) * 8'h80) ^ 8'(p * 8'h3C) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [23:0] a, input int k);
        int up = int'(a[15:12]);
        if (a[23:16] != 8'h00 || a[11:9] != 3'b000 || up < 1 || up > 3)
            return 8'hFF;
        return pat(up - 1, (int'(a[8:0]) + k) % 512);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: set data, rise, fall, then let the output settle
    task automatic sbit(input logic b);
        spi_si = b;
        wait_clk(4);
        spi_sclk = 1'b1;
        wait_clk(4);
        spi_sclk = 1'b0;
        wait_clk(4);
    endtask

    task automatic select();
        spi_cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic deselect();
        spi_cs_n = 1'b1;
        wait_clk(6);
    endtask

    // Header bits; counts bits before the 40th on which the output was enabled
    task automatic header(input logic [7:0] op, input logic [23:0] a, output int early);
        logic [39:0] w = {op, a, 8'h5A};
        early = 0;
        for (int i = 39; i >= 0; i--) begin
            sbit(w[i]);
            if (i > 0 && spi_so_oe !== 1'b0) early++;
        end
    endtask

    task automatic read_byte(output logic [7:0] b, output bit oe_ok);
        oe_ok = 1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            if (spi_so_oe !== 1'b1) oe_ok = 0;
            b = {b[6:0], spi_so};
            sbit(1'b0);
        end
    endtask

    task automatic preload();
        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 512; o++) begin
                wr_en = 1'b1; wr_page = 2'(p); wr_offset = 9'(o); wr_data = pat(p, o);
                wait_clk(1);
            end
        end
        wr_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int early;
        logic [7:0] b;
        bit oe_ok;
        logic so_before;

        wait_clk(5);
        // R13: output disabled while in reset
        check(spi_so_oe === 1'b0, "R13 reset oe", int'(spi_so_oe), 0);
        rst_n = 1'b1;
        wait_clk(2);
        preload();

        // Table of reads
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  op  = VECS[v][47:40];
            logic [23:0] a   = VECS[v][39:16];
            int          n   = int'(VECS[v][15:0]);
            select();
            header(op, a, early);
            // R4: no output during opcode, address and dummy byte
            check(early == 0, "R4 header hi-Z", early, 0);
            for (int k = 0; k < n; k++) begin
                read_byte(b, oe_ok);
                if (op == 8'h48) begin
                    // R2 R5 R6 R7 R8 R9: byte from decoded page and offset
                    check(b == exp_byte(a, k) && oe_ok, "R5/R6/R7/R8/R9 data",
                          int'(b), int'(exp_byte(a, k)));
                end else begin
                    // R1: other opcode never enables output
                    check(!oe_ok && spi_so_oe === 1'b0, "R1 bad opcode", int'(spi_so_oe), 0);
                end
            end
            deselect();
        end

        // R3 R11: first data bit only after the falling edge following bit 39
        select();
        header(8'h48, 24'h002000, early);
        check(spi_so_oe === 1'b1 && spi_so === pat(1, 0)[7], "R3 first bit after dummy",
              int'(spi_so), int'(pat(1, 0)[7]));
        so_before = spi_so;
        spi_sclk = 1'b1;
        wait_clk(6);
        // R11: rising edge leaves the output bit alone (next bit differs)
        check(spi_so === so_before, "R11 no change on rise", int'(spi_so), int'(so_before));
        spi_sclk = 1'b0;
        wait_clk(6);
        check(spi_so === pat(1, 0)[6], "R11 change on fall", int'(spi_so), int'(pat(1, 0)[6]));
        // R10: chip select high disables output at once
        spi_cs_n = 1'b1;
        #1;
        check(spi_so_oe === 1'b0, "R10 immediate hi-Z", int'(spi_so_oe), 0);
        wait_clk(6);

        // R10: abort in the middle of the address, then a clean read
        select();
        for (int i = 0; i < 20; i++) sbit(1'b1);
        deselect();
        select();
        header(8'h48, 24'h003005, early);
        read_byte(b, oe_ok);
        check(b == pat(2, 5) && oe_ok && early == 0, "R10 restart after abort",
              int'(b), int'(pat(2, 5)));
        deselect();

        // R12: overwrite one byte and read it back
        wr_en = 1'b1; wr_page = 2'd2; wr_offset = 9'd300; wr_data = 8'h3E;
        wait_clk(1);
        wr_en = 1'b0;
        select();
        header(8'h48, 24'h00312C, early);
        read_byte(b, oe_ok);
        check(b == 8'h3E && oe_ok, "R12 preload write", int'(b), 8'h3E);
        deselect();

        // R13: reset in the middle of a read disables the output
        select();
        header(8'h48, 24'h001010, early);
        rst_n = 1'b0;
        wait_clk(2);
        check(spi_so_oe === 1'b0, "R13 reset mid read", int'(spi_so_oe), 0);
        rst_n = 1'b1;
        deselect();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule